// File: doc/BRIEF.md
# Multi-Channel Ramp-Compare Digitizer Back End

This block is the digital half of a ramp-compare (Wilkinson) conversion shared by many channels. A conversion sequence is started with one command and works through a chosen number of stored events. Each event is held in an analog memory column. For each column the block resets a shared counter, lets the analog side settle, and then raises the ramp enable. While the ramp runs, the counter advances once per clock and is presented in Gray code to every channel.

Each channel has a comparator input that goes high when the ramp crosses the channel's held voltage. The input passes through a two-stage synchronizer. The channel then captures the shared Gray code and the state of its gain-select input. The ramp ends early once every channel has captured a code, or else when the counter reaches its top value. The column is then written out in one cycle, with each code converted to binary and a full-scale code for any silent channel. After the last column, a single done pulse is raised. Conversion always finishes before any readout, so the write port is the only result interface.

Top module: `wk_digitizer`

## Requirements
- R1: After reset, `ramp_on`, `wr_en`, `conv_done` and `busy` are 0 and `gray_cnt` is 0.
- R2: `gray_cnt` is 0 in the first cycle of every ramp. While the ramp runs, consecutive values differ in exactly one bit. The value is the Gray code of a binary count that rises by one per clock.
- R3: A channel whose comparator input is raised in a ramp cycle where the binary count is V reports the binary code V+2 for that column. The extra 2 counts come from the two synchronizer stages. A channel captures at most once per column.
- R4: `wr_gain[c]` is 1 (high gain) when the channel's gain-select input was 1 at the cycle of capture. It is 0 for a channel that never captured.
- R5: A channel whose comparator never fires during the ramp reports the full-scale code, all ones (4095 at 12 bits). Such a ramp stops with the counter held at its top value.
- R6: Once all channels have captured, the ramp ends after one more cycle. During the write cycle, the counter shows the highest captured code plus 2.
- R7: Columns are written in the order 0, 1, … up to `last_col` (sampled at start). Each column gets exactly one `wr_en` cycle, with `wr_col` equal to the column index. Every ramp is preceded by a settle interval with the ramp off.
- R8: `conv_done` is a one-cycle pulse in the cycle after the final write. `busy` is 0 from that cycle on.
- R9: A start command given while `busy` is 1 is ignored. The running sequence keeps its column count and order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start | input | 1 | Start a conversion sequence (ignored while busy) |
| last_col | input | 4 | Index of the last column to convert |
| cmp_in | input | 36 | Per-channel end-of-ramp comparator inputs |
| gain_hi | input | 36 | Per-channel gain-select (1 = high gain) |
| ramp_on | output | 1 | Ramp enable to the analog side |
| gray_cnt | output | 12 | Shared Gray-coded conversion count |
| busy | output | 1 | Sequence in progress |
| wr_en | output | 1 | Column write strobe |
| wr_col | output | 4 | Column being written |
| wr_code | output | 432 | Binary codes, channel c at bits [12c+11:12c] |
| wr_gain | output | 36 | Captured gain flags |
| conv_done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
A comparator raised in a cycle where the bench reads count V is due to yield code V+2 at the column's write. This is because the input crosses two synchronizer registers before the capture register takes the code. The bench therefore records V+2 as the expected value at the moment it raises each input. The ramp is due to stop one cycle after the last capture. For that reason, the frozen count is compared against the highest expected code plus 2 in the write cycle. The done pulse is checked in the cycle after the final write and checked again to be low one cycle later. All outputs are sampled on the falling clock edge.

// File: rtl/wk_pkg.sv
package wk_pkg;

    // Sequencer phases for one conversion sequence
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_RAMP   = 2'd2,
        ST_WRITE  = 2'd3
    } wk_state_e;

endpackage

// File: rtl/wk_gray_ctr.sv
module wk_gray_ctr #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] gray_o,
    output logic         at_max_o
);

    typedef struct packed {
        logic [W-1:0] bin;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.bin = '0;
        end else if (en && !at_max_o) begin
            st_d.bin = st_q.bin + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gray_o   = st_q.bin ^ (st_q.bin >> 1);
    assign at_max_o = &st_q.bin;

    AST_GRAY_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && !at_max_o) |=> ($countones(gray_o ^ $past(gray_o)) == 1))
        else $error("gray step not single bit"); // R2

    AST_HOLD_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (at_max_o && !clr) |=> at_max_o)
        else $error("counter wrapped"); // R5

endmodule

// File: rtl/wk_channel.sv
module wk_channel #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmp_i,
    input  logic         gain_i,
    input  logic         arm_i,
    input  logic         clr_i,
    input  logic [W-1:0] gray_i,
    output logic         hit_o,
    output logic         gain_o,
    output logic [W-1:0] code_o
);

    typedef struct packed {
        logic         s1;
        logic         s2;
        logic         hit;
        logic         gain;
        logic [W-1:0] code;
    } ch_t;

    ch_t st_d, st_q;
    logic [W-1:0] bin;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = cmp_i;
        st_d.s2 = st_q.s1;
        if (clr_i) begin
            st_d.hit  = 1'b0;
            st_d.gain = 1'b0;
            st_d.code = '0;
        end else if (arm_i && st_q.s2 && !st_q.hit) begin
            st_d.hit  = 1'b1;
            st_d.gain = gain_i;
            st_d.code = gray_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Gray to binary: each binary bit is the parity of the code bits at and above it
    always_comb begin
        for (int i = 0; i < W; i++) begin
            bin[i] = ^(st_q.code >> i);
        end
    end

    assign hit_o  = st_q.hit;
    assign gain_o = st_q.gain;
    assign code_o = st_q.hit ? bin : {W{1'b1}};

    AST_CAPTURE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hit && !clr_i) |=> (st_q.hit && $stable(st_q.code)))
        else $error("captured code changed"); // R3

    AST_NO_CAPTURE_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_i && !st_q.hit) |=> !st_q.hit)
        else $error("capture outside ramp"); // R3

endmodule

// File: rtl/wk_seq.sv
module wk_seq
    import wk_pkg::*;
#(
    parameter int COL_W      = 4,
    parameter int SETTLE_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] last_col_i,
    input  logic             all_hit_i,
    input  logic             at_max_i,
    output logic             ramp_o,
    output logic             clr_o,
    output logic             wr_o,
    output logic [COL_W-1:0] col_o,
    output logic             done_o,
    output logic             busy_o
);

    localparam int SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);

    typedef struct packed {
        wk_state_e        st;
        logic [COL_W-1:0] col;
        logic [COL_W-1:0] last;
        logic [SW-1:0]    settle;
        logic             done;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    st_d.st     = ST_SETTLE;
                    st_d.col    = '0;
                    st_d.last   = last_col_i;
                    st_d.settle = '0;
                end
            end
            ST_SETTLE: begin
                if (st_q.settle == SETTLE_LAST) st_d.st = ST_RAMP;
                else                            st_d.settle = st_q.settle + 1'b1;
            end
            ST_RAMP: begin
                if (all_hit_i || at_max_i) st_d.st = ST_WRITE;
            end
            ST_WRITE: begin
                if (st_q.col == st_q.last) begin
                    st_d.st   = ST_IDLE;
                    st_d.done = 1'b1;
                end else begin
                    st_d.col    = st_q.col + 1'b1;
                    st_d.st     = ST_SETTLE;
                    st_d.settle = '0;
                end
            end
            default: st_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{st: ST_IDLE, default: '0};
        else        st_q <= st_d;
    end

    assign ramp_o = (st_q.st == ST_RAMP);
    assign clr_o  = (st_q.st == ST_SETTLE);
    assign wr_o   = (st_q.st == ST_WRITE);
    assign busy_o = (st_q.st != ST_IDLE);
    assign col_o  = st_q.col;
    assign done_o = st_q.done;

    AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |=> !wr_o)
        else $error("write longer than one cycle"); // R7

    AST_RAMP_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ramp_o) |-> $past(clr_o))
        else $error("ramp without settle"); // R7

    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(wr_o) && !busy_o))
        else $error("done not after final write"); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o)
        else $error("done held"); // R8

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !wr_o) |=> $stable(col_o))
        else $error("start disturbed sequence"); // R9

endmodule

// File: rtl/wk_digitizer.sv
module wk_digitizer #(
    parameter int N_CH       = 36,
    parameter int CNT_W      = 12,
    parameter int N_COL      = 16,
    parameter int SETTLE_CYC = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    conv_start,
    input  logic [$clog2(N_COL)-1:0] last_col,
    input  logic [N_CH-1:0]         cmp_in,
    input  logic [N_CH-1:0]         gain_hi,
    output logic                    ramp_on,
    output logic [CNT_W-1:0]        gray_cnt,
    output logic                    busy,
    output logic                    wr_en,
    output logic [$clog2(N_COL)-1:0] wr_col,
    output logic [N_CH*CNT_W-1:0]   wr_code,
    output logic [N_CH-1:0]         wr_gain,
    output logic                    conv_done
);

    localparam int COL_W = $clog2(N_COL);

    logic            ctr_clr;
    logic            at_max;
    logic [N_CH-1:0] hits;
    logic            all_hit;

    assign all_hit = &hits;

    wk_seq #(
        .COL_W      (COL_W),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (conv_start),
        .last_col_i (last_col),
        .all_hit_i  (all_hit),
        .at_max_i   (at_max),
        .ramp_o     (ramp_on),
        .clr_o      (ctr_clr),
        .wr_o       (wr_en),
        .col_o      (wr_col),
        .done_o     (conv_done),
        .busy_o     (busy)
    );

    wk_gray_ctr #(
        .W (CNT_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ctr_clr),
        .en       (ramp_on),
        .gray_o   (gray_cnt),
        .at_max_o (at_max)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        wk_channel #(
            .W (CNT_W)
        ) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .cmp_i  (cmp_in[c]),
            .gain_i (gain_hi[c]),
            .arm_i  (ramp_on),
            .clr_i  (ctr_clr),
            .gray_i (gray_cnt),
            .hit_o  (hits[c]),
            .gain_o (wr_gain[c]),
            .code_o (wr_code[c*CNT_W +: CNT_W])
        );
    end

    AST_ALL_HIT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_on && all_hit) |=> wr_en)
        else $error("ramp continued after all captures"); // R6

endmodule

// File: tb/wk_digitizer_bench.sv
module wk_digitizer_bench;

    localparam int N_CH  = 36;
    localparam int CNT_W = 12;
    localparam int N_COL = 16;
    localparam int COL_W = 4;
    localparam int TOP   = (1 << CNT_W) - 1;
    localparam int NR    = 7;

    // Per-row stimulus: trigger count = base + step*c; skip: channels with c%skip==0 stay silent;
    // gmod: gain high when c%gmod==0. Row 6 silences every channel.
    localparam int T_BASE [NR] = '{0, 5, 40, 100, 3, 200, 0};
    localparam int T_STEP [NR] = '{1, 3, 2, 0, 7, 1, 0};
    localparam int T_SKIP [NR] = '{0, 0, 5, 0, 0, 7, 1};
    localparam int T_GMOD [NR] = '{2, 3, 0, 1, 4, 2, 1};

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    conv_start = 1'b0;
    logic [COL_W-1:0]        last_col = '0;
    logic [N_CH-1:0]         cmp_in = '0;
    logic [N_CH-1:0]         gain_hi = '0;
    logic                    ramp_on;
    logic [CNT_W-1:0]        gray_cnt;
    logic                    busy;
    logic                    wr_en;
    logic [COL_W-1:0]        wr_col;
    logic [N_CH*CNT_W-1:0]   wr_code;
    logic [N_CH-1:0]         wr_gain;
    logic                    conv_done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    wk_digitizer #(.N_CH(N_CH), .CNT_W(CNT_W), .N_COL(N_COL), .SETTLE_CYC(4)) u_wk_digitizer (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .last_col(last_col),
        .cmp_in(cmp_in), .gain_hi(gain_hi), .ramp_on(ramp_on), .gray_cnt(gray_cnt),
        .busy(busy), .wr_en(wr_en), .wr_col(wr_col), .wr_code(wr_code),
        .wr_gain(wr_gain), .conv_done(conv_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int g2b(input logic [CNT_W-1:0] g);
        logic [CNT_W-1:0] b;
        b[CNT_W-1] = g[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return int'(b);
    endfunction

    function automatic int trig_at(input int row, input int c);
        if (T_SKIP[row] != 0 && (c % T_SKIP[row]) == 0) return -1;
        return T_BASE[row] + T_STEP[row] * c;
    endfunction

    function automatic bit gain_of(input int row, input int c);
        return (T_GMOD[row] != 0) && ((c % T_GMOD[row]) == 0);
    endfunction

    // Runs one sequence of lc+1 columns; column k uses table row (k+row_off)%NR.
    task automatic run_seq(input int lc, input int row_off, input bit poke);
        int  exp_code [N_CH];
        bit  exp_gain [N_CH];
        bit  fired [N_CH];
        int  col = 0;
        int  hi_code = -1;
        int  n_fired = 0;
        int  gray_bad = 0;
        bit  prev_ramp = 1'b0;
        bit  poked = 1'b0;
        logic [CNT_W-1:0] prev_gray = '0;
        for (int c = 0; c < N_CH; c++) begin
            exp_code[c] = TOP; exp_gain[c] = 1'b0; fired[c] = 1'b0;
        end
        @(negedge clk);
        last_col   = COL_W'(lc);
        conv_start = 1'b1;
        for (int it = 0; it < 120000; it++) begin
            @(negedge clk);
            conv_start = 1'b0;
            if (ramp_on) begin
                int row = (col + row_off) % NR;
                int bin = g2b(gray_cnt);
                if (!prev_ramp) chk(gray_cnt == '0, "R2 ramp starts at zero", int'(gray_cnt), 0);
                else if ($countones(gray_cnt ^ prev_gray) != 1) gray_bad++;
                for (int c = 0; c < N_CH; c++) begin
                    if (!fired[c] && trig_at(row, c) == bin) begin
                        fired[c]    = 1'b1;
                        cmp_in[c]   = 1'b1;
                        gain_hi[c]  = gain_of(row, c);
                        exp_code[c] = bin + 2;
                        exp_gain[c] = gain_of(row, c);
                        n_fired++;
                        if (bin + 2 > hi_code) hi_code = bin + 2;
                    end
                end
                if (poke && !poked && bin == 50) begin
                    poked      = 1'b1;
                    conv_start = 1'b1;
                    last_col   = '0;
                end
                prev_gray = gray_cnt;
            end
            prev_ramp = ramp_on;
            if (wr_en) begin
                chk(int'(wr_col) == col, "R7 column order", int'(wr_col), col);
                chk(gray_bad == 0, "R2 single-bit steps", gray_bad, 0);
                for (int c = 0; c < N_CH; c++) begin
                    int act = int'(wr_code[c*CNT_W +: CNT_W]);
                    if (fired[c]) chk(act == exp_code[c], "R3 captured code", act, exp_code[c]);
                    else          chk(act == TOP, "R5 full-scale code", act, TOP);
                    chk(wr_gain[c] == exp_gain[c], "R4 gain flag", int'(wr_gain[c]), int'(exp_gain[c]));
                end
                if (n_fired == N_CH)
                    chk(g2b(gray_cnt) == hi_code + 2, "R6 early end", g2b(gray_cnt), hi_code + 2);
                else
                    chk(g2b(gray_cnt) == TOP, "R5 ramp held at top", g2b(gray_cnt), TOP);
                cmp_in  = '0;
                gain_hi = '0;
                for (int c = 0; c < N_CH; c++) begin
                    exp_code[c] = TOP; exp_gain[c] = 1'b0; fired[c] = 1'b0;
                end
                hi_code = -1; n_fired = 0; gray_bad = 0;
                col++;
            end else if (conv_done) begin
                chk(col == lc + 1, "R8 done after final column", col, lc + 1);
                chk(!busy, "R8 busy cleared", int'(busy), 0);
                if (poke) chk(col == lc + 1, "R9 start ignored while busy", col, lc + 1);
                @(negedge clk);
                chk(!conv_done, "R8 done is one pulse", int'(conv_done), 0);
                return;
            end
        end
        chk(1'b0, "R8 sequence never finished", 0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ramp_on,   "R1 ramp off",   int'(ramp_on), 0);
        chk(!wr_en,     "R1 no write",   int'(wr_en), 0);
        chk(!conv_done, "R1 no done",    int'(conv_done), 0);
        chk(!busy,      "R1 idle",       int'(busy), 0);
        chk(gray_cnt == '0, "R1 counter zero", int'(gray_cnt), 0);
        // table walk over all sixteen columns
        run_seq(N_COL - 1, 0, 1'b0);
        // start pulse while busy must not restart or shorten the sequence
        run_seq(2, 3, 1'b1);
        // directed: every channel silent, full-scale codes and zero gain flags
        run_seq(0, 6, 1'b0);
        // directed: every channel fires in the same cycle
        run_seq(0, 3, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule